// File: doc/BRIEF.md
# Packet Receive Address and CRC Filter

This block is the receive-side packet handler that sits behind a bit synchroniser and a start-pattern detector. When `sync_det` pulses, the bits that follow are taken as a packet. By then the preamble and start pattern have already gone past, so they never reach the output. The packet is read MSB first. It carries an optional length byte, an optional node-address byte, the payload, and a 16-bit CRC. Only the payload bytes come out, as a burst of bytes marked with valid and last flags.

The address byte can be checked in three ways. The first accepts only the programmed node address. The second also accepts 0x00 as a broadcast. The third accepts both 0x00 and 0xFF. A packet that is rejected by address, or whose length is too large, is dropped without any sign, and the block waits for the next start detection. The payload is held in a small buffer until the CRC has been checked. A packet that fails the CRC is then either delivered with its failure flagged, or flagged and thrown away, depending on a configuration bit.

Top module: `pkt_rx_filter`

## Requirements
- R1: After a `sync_det` pulse in idle, each cycle with `bit_vld`=1 supplies one bit, MSB of each byte first. The order is: the length byte (if `cfg_len_en`=1), then the address byte (if `cfg_adr_en`=1), then the payload, then the CRC with its high byte first. Only the payload bytes appear on `pay_data`, in the order they were received.
- R2: The payload byte count is the length byte when one is present, otherwise `cfg_fix_len`. A count of zero is legal: no bytes are delivered, but `pkt_done` still pulses.
- R3: No payload byte is output while a packet is being received. Delivery is one byte per cycle, with `pay_vld` held high for the whole burst and `pay_last` high on the final byte only. The first byte appears in the same cycle as `pkt_done`.
- R4: Address filter, selected by `cfg_adr_mode`. Mode 0 accepts only `cfg_node_adr`. Mode 1 also accepts 0x00. Modes 2 and 3 also accept 0x00 and 0xFF. A rejected packet gives no bytes and no `pkt_done`.
- R5: `adr_match` pulses for one cycle after the address byte is received, and only when that byte equals `cfg_node_adr` exactly. A broadcast value does not raise it.
- R6: The CRC uses the polynomial x^16+x^12+x^5+1 with seed 0xFFFF. It is computed MSB first over the length, address and payload bytes, with no final inversion. After the last CRC bit, `pkt_done` pulses for one cycle, and `crc_ok` is 1 in that cycle exactly when the received CRC matches.
- R7: With `cfg_crc_discard`=0, a packet with a bad CRC is still delivered, with `crc_ok`=0. With `cfg_crc_discard`=1, it gives `pkt_done` with `crc_ok`=0 and no bytes.
- R8: A payload count greater than MAX_PAY (16 by default) drops the packet silently: no bytes, no `pkt_done`.
- R9: Bits offered while no packet is active have no effect on any output or on the next packet.
- R10: While reset is held, `pay_vld`, `pay_last`, `pkt_done`, `crc_ok` and `adr_match` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| sync_det | input | 1 | Start pattern found; the packet begins with the next bit |
| bit_vld | input | 1 | `bit_in` holds a valid bit this cycle |
| bit_in | input | 1 | Serial data bit |
| cfg_len_en | input | 1 | Packet carries a length byte |
| cfg_adr_en | input | 1 | Packet carries an address byte |
| cfg_adr_mode | input | 2 | Broadcast acceptance mode |
| cfg_node_adr | input | 8 | Node address of this receiver |
| cfg_fix_len | input | 8 | Payload count when there is no length byte |
| cfg_crc_discard | input | 1 | Throw away packets with a bad CRC |
| pay_data | output | 8 | Payload byte |
| pay_vld | output | 1 | `pay_data` is valid |
| pay_last | output | 1 | Final payload byte of the packet |
| pkt_done | output | 1 | Packet accepted and its CRC checked (one-cycle pulse) |
| crc_ok | output | 1 | CRC result, valid with `pkt_done` |
| adr_match | output | 1 | Address byte equals the node address |

## Verification
The address byte is swept over the node address, 0x00, 0xFF and one other value in every filter mode. This separates exact matches, each broadcast rule, and the mode 2/3 aliasing. The length byte is swept across every value from 0 to MAX_PAY, and fixed-length and header-free packets are sent as well. Together these expose off-by-one errors in counting, ordering and the last flag. Packets with a corrupted CRC are sent in both discard settings to tell flagging apart from discarding. Oversized lengths and stray bits outside a packet, each followed by a good packet, show that the block drops them and then recovers.

// File: rtl/pkt_rx_pkg.sv
package pkt_rx_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_LEN, ST_ADR, ST_PAY, ST_CRC, ST_SEND
  } rx_state_e;

  localparam logic [15:0] CRC_SEED = 16'hFFFF;
  localparam logic [15:0] CRC_POLY = 16'h1021;

  // one serial CRC step, message bit enters at the top
  function automatic logic [15:0] crc16_step(input logic [15:0] c, input logic b);
    logic fb;
    fb = c[15] ^ b;
    return {c[14:0], 1'b0} ^ (fb ? CRC_POLY : 16'h0000);
  endfunction

  // address filter: exact node, plus 0x00 when mode!=0, plus 0xFF when mode[1]
  function automatic logic addr_accept(input logic [7:0] a, input logic [7:0] node,
                                       input logic [1:0] mode);
    return (a == node) || ((mode != 2'd0) && (a == 8'h00)) || (mode[1] && (a == 8'hFF));
  endfunction

  // state after the header fields that are still to come
  function automatic rx_state_e hdr_next(input logic adr_left, input logic [7:0] len);
    if (adr_left) return ST_ADR;
    if (len == 8'd0) return ST_CRC;
    return ST_PAY;
  endfunction

endpackage

// File: rtl/rx_deser.sv
module rx_deser #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              en,
  input  logic              bit_i,
  output logic [BYTE_W-1:0] byte_o,
  output logic              stb_o
);
  localparam int CW = $clog2(BYTE_W);
  localparam logic [CW-1:0] LAST = CW'(BYTE_W - 1);

  logic [CW-1:0]     cnt;
  logic [BYTE_W-1:0] sh;
  logic [BYTE_W-1:0] sh_nx;

  assign sh_nx = {sh[BYTE_W-2:0], bit_i};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      byte_o <= '0;
      stb_o  <= 1'b0;
    end else begin
      stb_o <= 1'b0;
      if (clr) begin
        cnt <= '0;
      end else if (en) begin
        sh  <= sh_nx;
        cnt <= cnt + CW'(1);
        if (cnt == LAST) begin
          byte_o <= sh_nx;
          stb_o  <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/crc16_ser.sv
module crc16_ser
  import pkt_rx_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        clr,
  input  logic        en,
  input  logic        bit_i,
  output logic [15:0] crc_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_o <= CRC_SEED;
    else if (clr) crc_o <= CRC_SEED;
    else if (en)  crc_o <= crc16_step(crc_o, bit_i);
  end
endmodule

// File: rtl/pay_buf.sv
module pay_buf #(
  parameter int DEPTH = 16,
  parameter int AW    = 4
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pkt_rx_filter.sv
module pkt_rx_filter
  import pkt_rx_pkg::*;
#(
  parameter int MAX_PAY = 16
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sync_det,
  input  logic       bit_vld,
  input  logic       bit_in,
  input  logic       cfg_len_en,
  input  logic       cfg_adr_en,
  input  logic [1:0] cfg_adr_mode,
  input  logic [7:0] cfg_node_adr,
  input  logic [7:0] cfg_fix_len,
  input  logic       cfg_crc_discard,
  output logic [7:0] pay_data,
  output logic       pay_vld,
  output logic       pay_last,
  output logic       pkt_done,
  output logic       crc_ok,
  output logic       adr_match
);
  localparam int AW = (MAX_PAY > 1) ? $clog2(MAX_PAY) : 1;
  localparam logic [7:0] MAX_LEN = 8'(MAX_PAY);

  rx_state_e   state;
  rx_state_e   first_st;
  logic [7:0]  plen;
  logic [7:0]  idx;
  logic [7:0]  rx_byte;
  logic [15:0] crc;
  logic        byte_stb;
  logic        rx_act;
  logic        start;
  logic        rx_bit;
  logic        first_drop;
  logic        crc_good;
  logic        keep;
  logic        idx_last;

  // named internal events
  assign start      = sync_det && (state == ST_IDLE);
  assign rx_act     = (state == ST_LEN) || (state == ST_ADR) ||
                      (state == ST_PAY) || (state == ST_CRC);
  assign rx_bit     = bit_vld && rx_act;
  assign crc_good   = (crc == 16'h0000);
  assign keep       = crc_good || !cfg_crc_discard;
  assign idx_last   = (idx == plen - 8'd1);
  assign first_st   = cfg_len_en ? ST_LEN : hdr_next(cfg_adr_en, cfg_fix_len);
  assign first_drop = !cfg_len_en && (cfg_fix_len > MAX_LEN);

  rx_deser #(.BYTE_W(8)) u_deser (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(rx_bit), .bit_i(bit_in),
    .byte_o(rx_byte), .stb_o(byte_stb)
  );

  crc16_ser u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start), .en(rx_bit), .bit_i(bit_in),
    .crc_o(crc)
  );

  pay_buf #(.DEPTH(MAX_PAY), .AW(AW)) u_buf (
    .clk(clk), .we(byte_stb && (state == ST_PAY)),
    .waddr(idx[AW-1:0]), .wdata(rx_byte),
    .raddr(idx[AW-1:0]), .rdata(pay_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      plen      <= '0;
      idx       <= '0;
      pkt_done  <= 1'b0;
      crc_ok    <= 1'b0;
      adr_match <= 1'b0;
    end else begin
      pkt_done  <= 1'b0;
      adr_match <= 1'b0;
      case (state)
        ST_IDLE: if (sync_det && !first_drop) begin
          state <= first_st;
          plen  <= cfg_fix_len;
          idx   <= '0;
        end
        ST_LEN: if (byte_stb) begin
          plen <= rx_byte;
          idx  <= '0;
          if (rx_byte > MAX_LEN) state <= ST_IDLE;
          else                   state <= hdr_next(cfg_adr_en, rx_byte);
        end
        ST_ADR: if (byte_stb) begin
          adr_match <= (rx_byte == cfg_node_adr);
          if (!addr_accept(rx_byte, cfg_node_adr, cfg_adr_mode)) state <= ST_IDLE;
          else                                                   state <= hdr_next(1'b0, plen);
        end
        ST_PAY: if (byte_stb) begin
          if (idx_last) begin
            state <= ST_CRC;
            idx   <= '0;
          end else begin
            idx <= idx + 8'd1;
          end
        end
        ST_CRC: if (byte_stb) begin
          if (idx == 8'd0) begin
            idx <= 8'd1;
          end else begin
            pkt_done <= 1'b1;
            crc_ok   <= crc_good;
            idx      <= '0;
            if (keep && (plen != 8'd0)) state <= ST_SEND;
            else                        state <= ST_IDLE;
          end
        end
        ST_SEND: begin
          if (idx_last) begin
            state <= ST_IDLE;
            idx   <= '0;
          end else begin
            idx <= idx + 8'd1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign pay_vld  = (state == ST_SEND);
  assign pay_last = pay_vld && idx_last;

endmodule

// File: rtl/pkt_rx_filter_chk.sv
module pkt_rx_filter_chk (
  input logic clk,
  input logic rst_n,
  input logic pay_vld,
  input logic pay_last,
  input logic pkt_done,
  input logic crc_ok,
  input logic cfg_crc_discard,
  input logic adr_match,
  input logic rx_act,
  input logic byte_stb
);
  AST_LAST_NEEDS_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    pay_last |-> pay_vld); // R3

  AST_BURST_CONTIGUOUS: assert property (@(posedge clk) disable iff (!rst_n)
    (pay_vld && !pay_last) |=> pay_vld); // R3

  AST_NO_OUT_DURING_RX: assert property (@(posedge clk) disable iff (!rst_n)
    rx_act |-> !pay_vld); // R3

  AST_BURST_AT_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pay_vld) |-> pkt_done); // R3

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    pkt_done |=> !pkt_done); // R6

  AST_DISCARD_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (pkt_done && !crc_ok && cfg_crc_discard) |-> !pay_vld); // R7

  AST_ADR_AFTER_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    adr_match |-> $past(byte_stb)); // R5
endmodule

bind pkt_rx_filter pkt_rx_filter_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pay_vld(pay_vld), .pay_last(pay_last),
  .pkt_done(pkt_done), .crc_ok(crc_ok), .cfg_crc_discard(cfg_crc_discard),
  .adr_match(adr_match), .rx_act(rx_act), .byte_stb(byte_stb)
);

// File: tb/pkt_rx_filter_tb.sv
`timescale 1ns/1ps
module pkt_rx_filter_tb;
  localparam int MAXP = 16;
  localparam logic [7:0] NODE = 8'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic sync_det = 1'b0, bit_vld = 1'b0, bit_in = 1'b0;
  logic cfg_len_en = 1'b0, cfg_adr_en = 1'b0, cfg_crc_discard = 1'b0;
  logic [1:0] cfg_adr_mode = 2'd0;
  logic [7:0] cfg_node_adr = NODE, cfg_fix_len = 8'd0;
  logic [7:0] pay_data;
  logic pay_vld, pay_last, pkt_done, crc_ok, adr_match;

  always #2.5 clk = ~clk;

  pkt_rx_filter #(.MAX_PAY(MAXP)) u_dut (
    .clk(clk), .rst_n(rst_n), .sync_det(sync_det), .bit_vld(bit_vld), .bit_in(bit_in),
    .cfg_len_en(cfg_len_en), .cfg_adr_en(cfg_adr_en), .cfg_adr_mode(cfg_adr_mode),
    .cfg_node_adr(cfg_node_adr), .cfg_fix_len(cfg_fix_len), .cfg_crc_discard(cfg_crc_discard),
    .pay_data(pay_data), .pay_vld(pay_vld), .pay_last(pay_last), .pkt_done(pkt_done),
    .crc_ok(crc_ok), .adr_match(adr_match)
  );

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [7:0] got [64];
  int got_n, last_at, done_n, adr_n, ok_seen, done_cyc, first_cyc;
  logic [7:0] fr [48];
  int fn;

  task automatic chk(input string req, input int act, input int exp, input string what);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc == 150000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  always @(negedge clk) if (rst_n) begin
    if (pay_vld) begin
      if (got_n == 0) first_cyc = cyc;
      if (got_n < 64) got[got_n] = pay_data;
      if (pay_last) last_at = got_n;
      got_n++;
    end
    if (pkt_done) begin done_n++; ok_seen = int'(crc_ok); done_cyc = cyc; end
    if (adr_match) adr_n++;
  end

  function automatic logic [7:0] pat(input int i, input int seed);
    return 8'((i * 29 + seed * 7 + 3) & 255);
  endfunction

  function automatic logic [15:0] crc_bytes(input int n);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < n; k++) begin
      c = c ^ {fr[k], 8'h00};
      for (int j = 0; j < 8; j++) c = c[15] ? ((c << 1) ^ 16'h1021) : (c << 1);
    end
    return c;
  endfunction

  task automatic clr_mon();
    got_n = 0; last_at = -1; done_n = 0; adr_n = 0; ok_seen = -1; done_cyc = -1; first_cyc = -2;
  endtask

  task automatic send_bits();
    @(posedge clk); #1 sync_det = 1'b1;
    @(posedge clk); #1 sync_det = 1'b0;
    for (int k = 0; k < fn; k++)
      for (int b = 7; b >= 0; b--) begin
        bit_in = fr[k][b]; bit_vld = 1'b1;
        @(posedge clk); #1 bit_vld = 1'b0;
        if (((k + b) % 3) == 0) begin @(posedge clk); #1; end
      end
    repeat (40) @(posedge clk);
    #1;
  endtask

  function automatic bit accepts(input int mode, input int a);
    case (mode)
      0: return a == int'(NODE);
      1: return a == int'(NODE) || a == 0;
      default: return a == int'(NODE) || a == 0 || a == 255;
    endcase
  endfunction

  task automatic run_pkt(input bit len_en, input bit adr_en, input int mode, input int adr,
                         input int plen, input int npay, input bit corrupt, input bit disc,
                         input int seed);
    logic [15:0] c;
    bit adr_rej, big, dropped;
    int exp_bytes, bad;
    string rq;
    cfg_len_en = len_en; cfg_adr_en = adr_en; cfg_adr_mode = 2'(mode);
    cfg_fix_len = len_en ? 8'd0 : 8'(plen); cfg_crc_discard = disc;
    fn = 0;
    if (len_en) begin fr[fn] = 8'(plen); fn++; end
    if (adr_en) begin fr[fn] = 8'(adr); fn++; end
    for (int i = 0; i < npay; i++) begin fr[fn] = pat(i, seed); fn++; end
    c = crc_bytes(fn);
    fr[fn] = c[15:8]; fn++;
    fr[fn] = c[7:0] ^ (corrupt ? 8'h01 : 8'h00); fn++;
    clr_mon();
    send_bits();
    big = plen > MAXP;
    adr_rej = adr_en && !accepts(mode, adr);
    dropped = big || adr_rej;
    exp_bytes = (!dropped && (!corrupt || !disc)) ? plen : 0;
    rq = big ? "R8" : (adr_rej ? "R4" : "R6");
    chk(rq, done_n, dropped ? 0 : 1, "pkt_done count");
    if (!dropped) chk(corrupt ? "R7" : "R6", ok_seen, corrupt ? 0 : 1, "crc_ok");
    chk((corrupt && disc) ? "R7" : "R2", got_n, exp_bytes, "payload byte count");
    bad = 0;
    for (int i = 0; i < exp_bytes && i < got_n; i++)
      if (got[i] != pat(i, seed)) bad++;
    chk("R1", bad, 0, "payload byte mismatches");
    if (exp_bytes > 0) begin
      chk("R3", last_at, exp_bytes - 1, "last flag position");
      chk("R3", first_cyc, done_cyc, "first byte cycle vs done cycle");
    end
    chk("R5", adr_n, (adr_en && !big && adr == int'(NODE)) ? 1 : 0, "adr_match pulses");
  endtask

  initial begin
    clr_mon();
    repeat (3) @(posedge clk);
    #1;
    // R10 reset state
    chk("R10", int'({pay_vld, pay_last, pkt_done, crc_ok, adr_match}), 0, "outputs in reset");
    rst_n = 1'b1;
    repeat (2) @(posedge clk);
    #1;
    // R9 stray bits without start detection
    clr_mon();
    for (int i = 0; i < 40; i++) begin
      bit_in = 1'(i % 3); bit_vld = 1'b1; @(posedge clk); #1;
    end
    bit_vld = 1'b0;
    repeat (30) @(posedge clk);
    #1;
    chk("R9", got_n + done_n + adr_n, 0, "activity from stray bits");
    run_pkt(1, 1, 0, NODE, 5, 5, 0, 0, 1);
    // R4 address sweep
    for (int m = 0; m < 4; m++) begin
      run_pkt(1, 1, m, NODE, 4, 4, 0, 0, m);
      run_pkt(1, 1, m, 8'h00, 4, 4, 0, 0, m + 4);
      run_pkt(1, 1, m, 8'hFF, 4, 4, 0, 0, m + 8);
      run_pkt(1, 1, m, 8'h33, 4, 4, 0, 0, m + 12);
    end
    // R2 length byte sweep
    for (int l = 0; l <= MAXP; l++) run_pkt(1, 0, 0, 0, l, l, 0, 0, l + 20);
    // R2 fixed length
    run_pkt(0, 1, 0, NODE, 0, 0, 0, 0, 40);
    run_pkt(0, 1, 0, NODE, 1, 1, 0, 0, 41);
    run_pkt(0, 1, 1, 8'h00, 7, 7, 0, 0, 42);
    run_pkt(0, 1, 0, NODE, MAXP, MAXP, 0, 0, 43);
    run_pkt(0, 0, 0, 0, 5, 5, 0, 0, 44);
    // R7 bad CRC in both settings
    for (int d = 0; d < 2; d++) begin
      run_pkt(1, 1, 0, NODE, 0, 0, 1, 1'(d), 50);
      run_pkt(1, 1, 0, NODE, 3, 3, 1, 1'(d), 51);
      run_pkt(1, 1, 0, NODE, MAXP, MAXP, 1, 1'(d), 52);
    end
    run_pkt(1, 1, 2, 8'hFF, 6, 6, 0, 1, 53);
    // R8 oversize, then recovery
    run_pkt(1, 0, 0, 0, MAXP + 1, 3, 0, 0, 60);
    run_pkt(1, 1, 0, NODE, 255, 2, 0, 0, 61);
    run_pkt(0, 0, 0, 0, MAXP + 1, MAXP + 1, 0, 0, 62);
    run_pkt(1, 1, 0, NODE, 9, 9, 0, 0, 63);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule